// File: doc/BRIEF.md
# Host Slot Select and Command Latch

This block is the host-facing front end of a plug-in peripheral card. The host addresses a slot by putting a 4-bit peripheral address on its address lines. The card takes part in a transfer only when that address equals its configured select code. On a falling edge of the active-low I/O strobe, the block stores the transfer direction and the 2-bit register code in a command register. The register code picks one of four host registers, R4 to R7. In the same step the block sets a request bit, and that bit holds the card's host flag in the busy state.

A local controller drives a small operation code to work with the block. It can read the stored command, clear it so the card is ready again, read the byte the host sent, and load a byte for the host to read. It can also force the host status line to report an error. For an input transfer the loaded byte is driven back onto the host data lines. This happens only while the card is addressed and the host is not running an interrupt poll. All host control lines are active-low, and the host is assumed to be synchronous to the block clock.

Top module: `hss_front`

## Requirements
- R1: When `host_pa` differs from `SEL_CODE` (default 7), `host_flag_n` and `host_sts_n` are high, `host_doe` is 0, and strobes change neither the command nor the captured data.
- R2: A falling edge of `host_strb_n` while selected and idle stores the register code (0..3 for R4..R7) and the direction, and sets the request bit. `host_dir_n` low means an output transfer (host to card).
- R3: While selected, `host_flag_n` is low when the request bit is clear and high while it is set.
- R4: `lp_op`=1 (read command) places {4'b0, request, output-transfer, register code} on `lp_rdata` after the next clock edge. Request is bit 3, output-transfer is bit 2 and the register code is bits 1:0.
- R5: `lp_op`=2 (clear command) clears the request, direction and register code, so the card reads ready again.
- R6: On an accepted output-transfer strobe, `host_din` is captured. `lp_op`=3 (read data) returns it on `lp_rdata` after the next edge.
- R7: `lp_op`=4 loads `lp_wdata` into the input register. `host_dout` carries that value with `host_doe`=1 only while selected, `host_dir_n` is high and `host_int_n` is high. Otherwise `host_dout` is 0 and `host_doe` is 0.
- R8: While selected with no error, `host_sts_n` is low.
- R9: `lp_op`=5 sets a persistent error that holds `host_sts_n` high, and `lp_op`=6 removes it. `lp_op`=0 is no operation.
- R10: A strobe that arrives while the request bit is set is ignored. Neither the command nor the captured data changes.
- R11: A strobe held low latches only once. Clearing the command while the strobe is still low does not re-latch it.
- R12: After synchronous reset the command, the error and both data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_pa | input | ADDR_W | Host peripheral address |
| host_rc | input | 2 | Host register code (R4..R7) |
| host_dir_n | input | 1 | Direction, low = output transfer |
| host_strb_n | input | 1 | Active-low I/O strobe |
| host_int_n | input | 1 | Active-low interrupt poll in progress |
| host_din | input | DATA_W | Data from host |
| host_dout | output | DATA_W | Data to host |
| host_doe | output | 1 | Drive enable for host_dout |
| host_flag_n | output | 1 | Low = card ready |
| host_sts_n | output | 1 | Low = card present, no error |
| lp_op | input | 3 | Local controller operation code |
| lp_wdata | input | DATA_W | Local controller write data |
| lp_rdata | output | DATA_W | Local controller read data |

## Verification
The bench targets a strobe that arrives while a request is pending. A design that overwrites the pending command here would return the second register code and data byte when the controller reads back. It also holds the strobe low across a clear. A level-sensitive latch would re-arm and read busy again after that clear. Other cases are an unmatched address, which must leave the command empty, and an interrupt poll during an input transfer, where a design that ignores the poll line would drive the host data bus.

// File: rtl/hss_pkg.sv
package hss_pkg;

    localparam int RC_W  = 2;
    localparam int CMD_W = RC_W + 2;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 3'd0,
        OP_RD_CMD  = 3'd1,
        OP_CLR_CMD = 3'd2,
        OP_RD_DATA = 3'd3,
        OP_LD_DATA = 3'd4,
        OP_SET_ERR = 3'd5,
        OP_CLR_ERR = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef struct packed {
        logic            req;
        logic            out_xfer;
        logic [RC_W-1:0] rc;
    } cmd_t;

    function automatic cmd_t make_cmd(input logic dir_n, input logic [RC_W-1:0] rc);
        cmd_t c;
        c.req      = 1'b1;
        c.out_xfer = ~dir_n;
        c.rc       = rc;
        return c;
    endfunction

endpackage

// File: rtl/hss_decode.sv
module hss_decode #(
    parameter int ADDR_W   = 4,
    parameter int SEL_CODE = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pa,
    input  logic              strb_n,
    output logic              hit,
    output logic              fire
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(SEL_CODE);

    logic [ADDR_W-1:0] bit_eq;
    logic              strb_q;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(pa[i] ^ SEL[i]);
    end

    assign hit = &bit_eq;

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b1;
        else     strb_q <= strb_n;
    end

    assign fire = hit & strb_q & ~strb_n;

    // R11
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/hss_cmd_latch.sv
module hss_cmd_latch
    import hss_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic            dir_n,
    input  logic [RC_W-1:0] rc,
    input  op_e             op,
    output cmd_t            cmd,
    output logic            take
);
    cmd_t cmd_q;
    logic clr;

    assign clr  = (op == OP_CLR_CMD);
    assign take = fire & ~cmd_q.req & ~clr;

    always_ff @(posedge clk) begin
        if (rst)       cmd_q <= '0;
        else if (clr)  cmd_q <= '0;
        else if (take) cmd_q <= make_cmd(dir_n, rc);
    end

    assign cmd = cmd_q;

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.req && op != OP_CLR_CMD) |=> $stable(cmd_q));

    // R2
    req_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd_q.req && op != OP_CLR_CMD) |=> cmd_q.req);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLR_CMD) |=> (cmd_q == '0));

endmodule

// File: rtl/hss_datapath.sv
module hss_datapath
    import hss_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              dir_n,
    input  logic              hit,
    input  logic              int_n,
    input  logic [DATA_W-1:0] hdin,
    input  op_e               op,
    input  logic [DATA_W-1:0] wdata,
    input  cmd_t              cmd,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] hdout,
    output logic              hdoe
);
    localparam int PAD_W = DATA_W - CMD_W;

    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            in_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (take && !dir_n)     out_q <= hdin;
            if (op == OP_LD_DATA)   in_q  <= wdata;
            case (op)
                OP_RD_CMD:  rd_q <= {{PAD_W{1'b0}}, cmd};
                OP_RD_DATA: rd_q <= out_q;
                default:    rd_q <= rd_q;
            endcase
        end
    end

    assign hdoe  = hit & int_n & dir_n;
    assign hdout = hdoe ? in_q : '0;
    assign rdata = rd_q;

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.req && op != OP_CLR_CMD) |=> $stable(out_q));

    // R7
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LD_DATA) |=> (in_q == $past(wdata)));

endmodule

// File: rtl/hss_flags.sv
module hss_flags
    import hss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic req,
    input  op_e  op,
    output logic flag_n,
    output logic sts_n
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst)                    err_q <= 1'b0;
        else if (op == OP_SET_ERR)  err_q <= 1'b1;
        else if (op == OP_CLR_ERR)  err_q <= 1'b0;
    end

    assign flag_n = ~(hit & ~req);
    assign sts_n  = ~(hit & ~err_q);

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SET_ERR) |=> (hit -> sts_n));

    // R9
    err_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && op != OP_CLR_ERR) |=> err_q);

endmodule

// File: rtl/hss_front.sv
module hss_front
    import hss_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int SEL_CODE = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_pa,
    input  logic [1:0]        host_rc,
    input  logic              host_dir_n,
    input  logic              host_strb_n,
    input  logic              host_int_n,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    output logic              host_flag_n,
    output logic              host_sts_n,
    input  logic [2:0]        lp_op,
    input  logic [DATA_W-1:0] lp_wdata,
    output logic [DATA_W-1:0] lp_rdata
);
    logic hit;
    logic fire;
    logic take;
    cmd_t cmd;
    op_e  op;

    assign op = op_e'(lp_op);

    hss_decode #(.ADDR_W(ADDR_W), .SEL_CODE(SEL_CODE)) u_dec (
        .clk(clk), .rst(rst), .pa(host_pa), .strb_n(host_strb_n),
        .hit(hit), .fire(fire)
    );

    hss_cmd_latch u_cmd (
        .clk(clk), .rst(rst), .fire(fire), .dir_n(host_dir_n),
        .rc(host_rc), .op(op), .cmd(cmd), .take(take)
    );

    hss_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .take(take), .dir_n(host_dir_n), .hit(hit),
        .int_n(host_int_n), .hdin(host_din), .op(op), .wdata(lp_wdata),
        .cmd(cmd), .rdata(lp_rdata), .hdout(host_dout), .hdoe(host_doe)
    );

    hss_flags u_flg (
        .clk(clk), .rst(rst), .hit(hit), .req(cmd.req), .op(op),
        .flag_n(host_flag_n), .sts_n(host_sts_n)
    );

    // R1
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit && !cmd.req && op != OP_CLR_CMD) |=> !cmd.req);

endmodule

// File: tb/sim_hss_front.sv
module sim_hss_front;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] host_pa;
    logic [1:0] host_rc;
    logic       host_dir_n, host_strb_n, host_int_n;
    logic [7:0] host_din, host_dout, lp_wdata, lp_rdata;
    logic       host_doe, host_flag_n, host_sts_n;
    logic [2:0] lp_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hss_front u0 (
        .clk(clk), .rst(rst), .host_pa(host_pa), .host_rc(host_rc),
        .host_dir_n(host_dir_n), .host_strb_n(host_strb_n), .host_int_n(host_int_n),
        .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .host_flag_n(host_flag_n), .host_sts_n(host_sts_n),
        .lp_op(lp_op), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lp(input logic [2:0] op, input logic [7:0] wd);
        lp_op = op; lp_wdata = wd;
        @(negedge clk);
        lp_op = 3'd0;
    endtask

    task automatic strobe(input logic [3:0] pa, input logic dir_n,
                          input logic [1:0] rc, input logic [7:0] d);
        host_pa = pa; host_dir_n = dir_n; host_rc = rc; host_din = d;
        host_strb_n = 1'b0;
        @(negedge clk);
        host_strb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        host_pa = 4'd7;
        #1;
        check("R12 flag_n", {7'd0, host_flag_n}, 8'h00);
        check("R8 sts_n", {7'd0, host_sts_n}, 8'h00);
        lp(3'd1, 8'h00);
        check("R12 cmd", lp_rdata, 8'h00);
        lp(3'd3, 8'h00);
        check("R12 out data", lp_rdata, 8'h00);
    endtask

    task automatic t_unselected;
        strobe(4'd3, 1'b0, 2'd1, 8'hAA);
        check("R1 flag_n", {7'd0, host_flag_n}, 8'h01);
        check("R1 sts_n", {7'd0, host_sts_n}, 8'h01);
        check("R1 doe", {7'd0, host_doe}, 8'h00);
        host_pa = 4'd7;
        lp(3'd1, 8'h00);
        check("R1 cmd untouched", lp_rdata, 8'h00);
        check("R1 flag ready", {7'd0, host_flag_n}, 8'h00);
    endtask

    task automatic t_output;
        strobe(4'd7, 1'b0, 2'd2, 8'h5A);
        check("R3 busy", {7'd0, host_flag_n}, 8'h01);
        lp(3'd1, 8'h00);
        check("R4 cmd", lp_rdata, 8'h0E);
        lp(3'd3, 8'h00);
        check("R6 data", lp_rdata, 8'h5A);
    endtask

    task automatic t_ignored;
        strobe(4'd7, 1'b1, 2'd1, 8'h33);
        lp(3'd1, 8'h00);
        check("R10 cmd kept", lp_rdata, 8'h0E);
        lp(3'd3, 8'h00);
        check("R10 data kept", lp_rdata, 8'h5A);
    endtask

    task automatic t_clear;
        lp(3'd2, 8'h00);
        check("R5 ready", {7'd0, host_flag_n}, 8'h00);
        lp(3'd1, 8'h00);
        check("R5 cmd zero", lp_rdata, 8'h00);
    endtask

    task automatic t_input;
        lp(3'd4, 8'hC3);
        strobe(4'd7, 1'b1, 2'd3, 8'h00);
        lp(3'd1, 8'h00);
        check("R2 cmd input R7", lp_rdata, 8'h0B);
        host_int_n = 1'b1; #1;
        check("R7 doe", {7'd0, host_doe}, 8'h01);
        check("R7 dout", host_dout, 8'hC3);
        host_int_n = 1'b0; #1;
        check("R7 poll doe", {7'd0, host_doe}, 8'h00);
        check("R7 poll dout", host_dout, 8'h00);
        host_int_n = 1'b1;
        @(negedge clk);
        lp(3'd2, 8'h00);
    endtask

    task automatic t_long_strobe;
        host_pa = 4'd7; host_dir_n = 1'b0; host_rc = 2'd0; host_din = 8'h11;
        host_strb_n = 1'b0;
        @(negedge clk);
        check("R11 first latch", {7'd0, host_flag_n}, 8'h01);
        lp(3'd2, 8'h00);
        lp(3'd1, 8'h00);
        check("R11 no relatch", lp_rdata, 8'h00);
        check("R11 ready", {7'd0, host_flag_n}, 8'h00);
        host_strb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_error;
        lp(3'd5, 8'h00);
        check("R9 error", {7'd0, host_sts_n}, 8'h01);
        @(negedge clk);
        check("R9 persists", {7'd0, host_sts_n}, 8'h01);
        lp(3'd6, 8'h00);
        check("R9 cleared", {7'd0, host_sts_n}, 8'h00);
        host_pa = 4'd8; #1;
        check("R8 unselected", {7'd0, host_sts_n}, 8'h01);
        host_pa = 4'd7;
    endtask

    initial begin
        rst = 1'b1; host_pa = 4'd0; host_rc = 2'd0; host_dir_n = 1'b1;
        host_strb_n = 1'b1; host_int_n = 1'b1; host_din = 8'h00;
        lp_op = 3'd0; lp_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unselected();
        t_output();
        t_ignored();
        t_clear();
        t_input();
        t_long_strobe();
        t_error();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule